// File: doc/BRIEF.md
# Boundary-Scan Pad Data Register

This block is the boundary-scan data register for a row of I/O pads. Each pad is one of three kinds, fixed at elaboration by a per-pad type code. A bidirectional or output-only pad owns three scan cells, for the pad input, the core output value and the core tristate control. An input-only pad owns one cell, for its pad input. All the cells form one serial chain from TDI to TDO.

On a gated data-register clock edge, the chain either captures the parallel pad and core values or shifts one place toward TDO. An update strobe copies the shifted values into a second stage of storage. When the external-test decode is active, that second stage drives each pad's output value and tristate control in place of the core.

A one-bit bypass register sits beside the chain, and a select input picks which of the two feeds TDO. TDO is re-timed on the falling clock edge. The TAP controller and the instruction decoder sit outside the block and drive its control inputs.

Top module: `bscan_io_chain`

## Requirements
- R1: The chain holds exactly one cell per input-only pad and three cells per pad of any other kind. The pad kind codes are 0 for bidirectional, 1 for input-only and 2 for output-only, two bits per pad, with pad p at bits [2p+1:2p] of `PAD_TYPES`. A 1 shifted in at TDI first reaches TDO after as many shift edges as there are cells.
- R2: Pad 0 is nearest TDO. Each pad's cells run, from the TDO side, pad input, then core output, then core tristate. The bit seen on TDO straight after a capture is pad 0's pad input.
- R3: On a rising edge with `dr_en_i`=1 and `shift_i`=0, each cell loads its parallel value: `pad_in_i`, `core_out_i` or `core_tri_i` of its pad.
- R4: On a rising edge with `dr_en_i`=1 and `shift_i`=1, each cell loads its neighbour on the TDI side, and the far cell loads `tdi_i`. With `dr_en_i`=0 the chain holds its contents.
- R5: The update stage loads the whole chain only on a rising edge with `update_i`=1. At any other time it holds, even while the chain shifts.
- R6: With `extest_i`=1, `pad_out_o[p]` and `pad_tri_o[p]` of a pad that has an output come from the update-stage copies of that pad's core-output and core-tristate cells.
- R7: With `extest_i`=0, `pad_out_o[p]` follows `core_out_i[p]` and `pad_tri_o[p]` follows `core_tri_i[p]` for every pad that has an output.
- R8: For an input-only pad, `pad_out_o` is 0 and `pad_tri_o` is 1 (high impedance) in every mode.
- R9: `rst_ni`=0 clears the chain and the bypass bit and drives TDO to 0. It loads the update stage with 1 in tristate cells and 0 elsewhere, so that under external test every pad is tristated with its output low. These values appear at once, without a clock edge.
- R10: With `bypass_sel_i`=1, TDO comes from a one-bit register. A capture loads that register with 0 and a shift loads it with `tdi_i`, so TDI reaches TDO one edge later.
- R11: TDO changes only on the falling edge of `tck_i`. It takes the value its selected source held after the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous test reset, active low |
| dr_en_i | input | 1 | Data-register clock gate: capture or shift on this edge |
| shift_i | input | 1 | 1 = shift, 0 = capture |
| update_i | input | 1 | Update strobe: copy the chain into the update stage |
| extest_i | input | 1 | External-test decode: the update stage drives the pads |
| bypass_sel_i | input | 1 | 1 = TDO from the bypass bit, 0 = from the chain |
| tdi_i | input | 1 | Serial data in |
| pad_in_i | input | N_PADS | Values seen at the pads |
| core_out_i | input | N_PADS | Output values from the core |
| core_tri_i | input | N_PADS | Tristate controls from the core, 1 = high impedance |
| tdo_o | output | 1 | Serial data out, re-timed on the falling edge |
| pad_out_o | output | N_PADS | Output value driven toward each pad |
| pad_tri_o | output | N_PADS | Tristate control toward each pad, 1 = high impedance |

## Verification
The hardest state to reach from the ports is a chosen drive on every output pad under external test. The only way in is a full-length serial load whose bit positions depend on the mix of pad kinds. One bit too many or too few moves every core-output and tristate value by a cell. The bench builds each load bit by bit from the pad kind list, checks that the pads keep their reset drive until the update strobe, and then checks each pad's value and tristate against the load. It also pulls reset in the middle of an active external-test drive, to show that every pad returns to high impedance at once.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    PAD_BIDIR = 2'd0,
    PAD_IN    = 2'd1,
    PAD_OUT   = 2'd2
  } pad_kind_e;

  localparam int unsigned MAX_PADS = 64;
  localparam int unsigned TYPES_W  = 2 * MAX_PADS;

  function automatic int unsigned kind_cells(logic [1:0] kind);
    return (kind == PAD_IN) ? 1 : 3;
  endfunction

  // chain offset of pad p (cells of pads 0..p-1)
  function automatic int unsigned chain_base(int unsigned p, logic [TYPES_W-1:0] types);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < p; i++) acc += kind_cells(types[2*i +: 2]);
    return acc;
  endfunction

  function automatic int unsigned chain_len(int unsigned n, logic [TYPES_W-1:0] types);
    return chain_base(n, types);
  endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell #(
  parameter logic UPD_RST = 1'b0
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic dr_en_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic cap_i,
  input  logic si_i,
  output logic so_o,
  output logic upd_o
);

  logic sh_q;
  logic up_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= 1'b0;
    else if (dr_en_i) sh_q <= shift_i ? si_i : cap_i;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       up_q <= UPD_RST;
    else if (update_i) up_q <= sh_q;
  end

  assign so_o  = sh_q;
  assign upd_o = up_q;

  AST_SHIFT_STEP: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (dr_en_i && shift_i) |=> (so_o == $past(si_i)));  // R4
  AST_CAPTURE_LOAD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (dr_en_i && !shift_i) |=> (so_o == $past(cap_i)));  // R3
  AST_HOLD_IDLE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !dr_en_i |=> $stable(so_o));  // R4
  AST_UPDATE_LOAD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    update_i |=> (upd_o == $past(so_o)));  // R5
  AST_UPDATE_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !update_i |=> $stable(upd_o));  // R5

endmodule

// File: rtl/bscan_pad.sv
module bscan_pad
  import bscan_pkg::*;
#(
  parameter logic [1:0] PAD_KIND = 2'd0,
  localparam int unsigned W = kind_cells(PAD_KIND)
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         dr_en_i,
  input  logic         shift_i,
  input  logic         update_i,
  input  logic         extest_i,
  input  logic         scan_in_i,
  output logic [W-1:0] scan_q_o,
  input  logic         pad_in_i,
  input  logic         core_out_i,
  input  logic         core_tri_i,
  output logic         pad_out_o,
  output logic         pad_tri_o
);

  logic [W:0] s;
  assign s[W]     = scan_in_i;
  assign scan_q_o = s[W-1:0];

  if (PAD_KIND == PAD_IN) begin : g_in_only
    logic unused_upd;
    logic unused_core;
    assign unused_core = core_out_i ^ core_tri_i;

    bscan_cell #(.UPD_RST(1'b0)) u_in (
      .tck_i, .rst_ni, .dr_en_i, .shift_i, .update_i,
      .cap_i (pad_in_i),
      .si_i  (s[1]),
      .so_o  (s[0]),
      .upd_o (unused_upd)
    );

    assign pad_out_o = 1'b0;
    assign pad_tri_o = 1'b1;
  end else begin : g_triplet
    // cell 0: pad input, cell 1: core output, cell 2: core tristate
    logic [2:0] cap_v;
    logic [2:0] upd_v;
    logic       unused_upd;
    assign cap_v      = {core_tri_i, core_out_i, pad_in_i};
    assign unused_upd = upd_v[0];

    for (genvar j = 0; j < 3; j++) begin : g_cell
      bscan_cell #(.UPD_RST(j == 2)) u_cell (
        .tck_i, .rst_ni, .dr_en_i, .shift_i, .update_i,
        .cap_i (cap_v[j]),
        .si_i  (s[j+1]),
        .so_o  (s[j]),
        .upd_o (upd_v[j])
      );
    end

    assign pad_out_o = extest_i ? upd_v[1] : core_out_i;
    assign pad_tri_o = extest_i ? upd_v[2] : core_tri_i;

    AST_EXTEST_OUT: assert property (@(posedge tck_i) disable iff (!rst_ni)
      (extest_i && $past(update_i)) |-> (pad_out_o == $past(s[1])));  // R6
    AST_EXTEST_TRI: assert property (@(posedge tck_i) disable iff (!rst_ni)
      (extest_i && $past(update_i)) |-> (pad_tri_o == $past(s[2])));  // R6
  end

endmodule

// File: rtl/bscan_tdo.sv
module bscan_tdo (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic dr_en_i,
  input  logic shift_i,
  input  logic bypass_sel_i,
  input  logic tdi_i,
  input  logic chain_i,
  output logic tdo_o
);

  logic byp_q;
  logic tdo_d;
  logic tdo_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)      byp_q <= 1'b0;
    else if (dr_en_i) byp_q <= shift_i & tdi_i;
  end

  assign tdo_d = bypass_sel_i ? byp_q : chain_i;

  // opposite edge to TDI sampling
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) tdo_q <= 1'b0;
    else         tdo_q <= tdo_d;
  end

  assign tdo_o = tdo_q;

  AST_BYPASS_STEP: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (dr_en_i && shift_i) |=> (byp_q == $past(tdi_i)));  // R10
  AST_TDO_RETIME: assert property (@(negedge tck_i) disable iff (!rst_ni)
    rst_ni |=> (tdo_o == $past(tdo_d)));  // R11

endmodule

// File: rtl/bscan_io_chain.sv
module bscan_io_chain
  import bscan_pkg::*;
#(
  parameter int unsigned            N_PADS    = 5,
  parameter logic [2*N_PADS-1:0]    PAD_TYPES = 10'b01_00_10_01_00
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              dr_en_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              extest_i,
  input  logic              bypass_sel_i,
  input  logic              tdi_i,
  input  logic [N_PADS-1:0] pad_in_i,
  input  logic [N_PADS-1:0] core_out_i,
  input  logic [N_PADS-1:0] core_tri_i,
  output logic              tdo_o,
  output logic [N_PADS-1:0] pad_out_o,
  output logic [N_PADS-1:0] pad_tri_o
);

  localparam logic [TYPES_W-1:0] TYPES_EXT = TYPES_W'(PAD_TYPES);
  localparam int unsigned        CHAIN_LEN = chain_len(N_PADS, TYPES_EXT);

  // chain[k] is cell k, cell 0 next to TDO; chain[CHAIN_LEN] is TDI
  logic [CHAIN_LEN:0] chain;
  assign chain[CHAIN_LEN] = tdi_i;

  for (genvar p = 0; p < N_PADS; p++) begin : g_pad
    localparam logic [1:0]  KIND = PAD_TYPES[2*p +: 2];
    localparam int unsigned BASE = chain_base(p, TYPES_EXT);
    localparam int unsigned W    = kind_cells(KIND);

    bscan_pad #(.PAD_KIND(KIND)) u_pad (
      .tck_i      (tck_i),
      .rst_ni     (rst_ni),
      .dr_en_i    (dr_en_i),
      .shift_i    (shift_i),
      .update_i   (update_i),
      .extest_i   (extest_i),
      .scan_in_i  (chain[BASE+W]),
      .scan_q_o   (chain[BASE+W-1:BASE]),
      .pad_in_i   (pad_in_i[p]),
      .core_out_i (core_out_i[p]),
      .core_tri_i (core_tri_i[p]),
      .pad_out_o  (pad_out_o[p]),
      .pad_tri_o  (pad_tri_o[p])
    );
  end

  bscan_tdo u_tdo (
    .tck_i        (tck_i),
    .rst_ni       (rst_ni),
    .dr_en_i      (dr_en_i),
    .shift_i      (shift_i),
    .bypass_sel_i (bypass_sel_i),
    .tdi_i        (tdi_i),
    .chain_i      (chain[0]),
    .tdo_o        (tdo_o)
  );

  AST_RESET_SAFE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (extest_i && !$past(rst_ni)) |-> ((pad_out_o == '0) && (&pad_tri_o)));  // R9

endmodule

// File: tb/tb_bscan_io_chain.sv
module tb_bscan_io_chain;

  localparam int          NP    = 5;
  // pad4 in, pad3 bidir, pad2 out-only, pad1 in, pad0 bidir
  localparam logic [9:0]  TYPES = {2'd1, 2'd0, 2'd2, 2'd1, 2'd0};

  function automatic bit is_in(int p);
    return TYPES[2*p +: 2] == 2'd1;
  endfunction

  function automatic int tb_len();
    int n = 0;
    for (int p = 0; p < NP; p++) n += is_in(p) ? 1 : 3;
    return n;
  endfunction

  localparam int LEN = tb_len();

  logic tck = 1'b0;
  logic rst_ni, dr_en, shift, upd, extest, byp, tdi;
  logic [NP-1:0] pin, cout, ctri;
  logic tdo;
  logic [NP-1:0] pad_out, pad_tri;

  always #4 tck = ~tck;

  bscan_io_chain #(.N_PADS(NP), .PAD_TYPES(TYPES)) dut (
    .tck_i(tck), .rst_ni(rst_ni), .dr_en_i(dr_en), .shift_i(shift),
    .update_i(upd), .extest_i(extest), .bypass_sel_i(byp), .tdi_i(tdi),
    .pad_in_i(pin), .core_out_i(cout), .core_tri_i(ctri),
    .tdo_o(tdo), .pad_out_o(pad_out), .pad_tri_o(pad_tri)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference: q[0] is the bit next to TDO
  bit q[$];
  bit mupd[$];
  bit mbyp;

  task automatic model_reset();
    q = {}; mupd = {}; mbyp = 0;
    for (int p = 0; p < NP; p++) begin
      q.push_back(0); mupd.push_back(0);
      if (!is_in(p)) begin
        q.push_back(0); q.push_back(0);
        mupd.push_back(0); mupd.push_back(1);
      end
    end
  endtask

  task automatic model_edge();
    bit old[$];
    old = q;
    if (dr_en) begin
      if (shift) begin
        mbyp = tdi;
        void'(q.pop_front());
        q.push_back(tdi);
      end else begin
        mbyp = 0;
        q = {};
        for (int p = 0; p < NP; p++) begin
          q.push_back(pin[p]);
          if (!is_in(p)) begin q.push_back(cout[p]); q.push_back(ctri[p]); end
        end
      end
    end
    if (upd) mupd = old;
  endtask

  task automatic pads_from(input bit src[$], input bit ext,
                           output logic [NP-1:0] eo, output logic [NP-1:0] et);
    int idx = 0;
    for (int p = 0; p < NP; p++) begin
      if (is_in(p)) begin
        eo[p] = 0; et[p] = 1; idx += 1;
      end else begin
        eo[p] = ext ? src[idx+1] : cout[p];
        et[p] = ext ? src[idx+2] : ctri[p];
        idx += 3;
      end
    end
  endtask

  task automatic compare();
    logic [NP-1:0] eo, et;
    bit mt;
    mt = byp ? mbyp : q[0];
    pads_from(mupd, extest, eo, et);
    check(tdo === mt, "R4 tdo vs reference", tdo, mt);
    check(pad_out === eo, "R6 pad_out vs reference", pad_out, eo);
    check(pad_tri === et, "R6 pad_tri vs reference", pad_tri, et);
  endtask

  task automatic step(input bit mid_chk = 0);
    logic old;
    old = tdo;
    @(posedge tck);
    model_edge();
    if (mid_chk) begin
      #1;
      check(tdo === old, "R11 tdo held past rising edge", tdo, old);
    end
    @(negedge tck);
    #1;
    compare();
  endtask

  task automatic set_ctl(input bit en, input bit sh, input bit up, input bit d);
    dr_en = en; shift = sh; upd = up; tdi = d;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] eo, et;
    logic [31:0]   d;
    bit            dq[$];
    bit            exp_bits[$];
    int            found;

    rst_ni = 0; extest = 1; byp = 0;
    set_ctl(0, 0, 0, 0);
    pin = '0; cout = '0; ctri = '0;
    model_reset();
    repeat (3) @(negedge tck);
    #1;
    // R9 reset state
    check(tdo === 1'b0, "R9 tdo in reset", tdo, 0);
    check(pad_tri === '1, "R9 tristate in reset under extest", pad_tri, 5'h1f);
    check(pad_out === '0, "R9 output low in reset under extest", pad_out, 0);
    rst_ni = 1;

    // R1 chain length by marker
    set_ctl(1, 0, 0, 0);
    step();
    found = 0;
    for (int k = 1; k <= 2 * LEN; k++) begin
      set_ctl(1, 1, 0, (k == 1));
      step();
      if (found == 0 && tdo === 1'b1) found = k;
    end
    check(found == LEN, "R1 marker reaches tdo after chain length", found, LEN);

    // R2/R3 capture and scan out
    pin = 5'b10110; cout = 5'b01101; ctri = 5'b11010;
    set_ctl(1, 0, 0, 0);
    step();
    check(tdo === pin[0], "R2 first bit is pad0 input", tdo, pin[0]);
    exp_bits = {};
    for (int p = 0; p < NP; p++) begin
      exp_bits.push_back(pin[p]);
      if (!is_in(p)) begin exp_bits.push_back(cout[p]); exp_bits.push_back(ctri[p]); end
    end
    for (int i = 1; i < LEN; i++) begin
      set_ctl(1, 1, 0, 0);
      step();
      check(tdo === exp_bits[i], "R3 captured bit order", tdo, exp_bits[i]);
    end

    // R4 hold with gate low
    begin
      logic held;
      held = tdo;
      for (int i = 0; i < 3; i++) begin
        set_ctl(0, 1, 0, i[0]);
        step();
        check(tdo === held, "R4 chain holds with gate low", tdo, held);
      end
    end

    // R5/R6 load a drive pattern under extest
    extest = 1;
    d = 32'h0000_05B3;
    dq = {};
    for (int i = 0; i < LEN; i++) begin
      dq.push_back(d[i]);
      set_ctl(1, 1, 0, d[i]);
      step();
    end
    check(pad_tri === '1, "R5 no update yet: pads tristated", pad_tri, 5'h1f);
    check(pad_out === '0, "R5 no update yet: outputs low", pad_out, 0);
    set_ctl(0, 0, 1, 0);
    step();
    set_ctl(0, 0, 0, 0);
    pads_from(dq, 1, eo, et);
    check(pad_out === eo, "R6 extest drives update out bits", pad_out, eo);
    check(pad_tri === et, "R6 extest drives update tristate bits", pad_tri, et);
    check(pad_tri[1] === 1'b1 && pad_tri[4] === 1'b1 && pad_out[1] === 1'b0 && pad_out[4] === 1'b0,
          "R8 input-only pads idle under extest", {pad_tri[4], pad_tri[1]}, 3);

    // R5 shifting without update leaves pads alone
    d = 32'h0000_02A4;
    for (int i = 0; i < LEN; i++) begin
      set_ctl(1, 1, 0, d[i]);
      step();
      check(pad_out === eo && pad_tri === et, "R5 pads stable while shifting",
            {pad_tri, pad_out}, {et, eo});
    end

    // R7 core drive when extest is off
    extest = 0;
    for (int v = 0; v < 3; v++) begin
      cout = 5'(7 * v + 5); ctri = 5'(~(3 * v + 1));
      set_ctl(0, 0, 0, 0);
      step();
      for (int p = 0; p < NP; p++) begin
        if (is_in(p)) begin
          check(pad_out[p] === 1'b0 && pad_tri[p] === 1'b1, "R8 input-only pad with core path",
                {pad_tri[p], pad_out[p]}, 2);
        end else begin
          check(pad_out[p] === cout[p], "R7 core output passes", pad_out[p], cout[p]);
          check(pad_tri[p] === ctri[p], "R7 core tristate passes", pad_tri[p], ctri[p]);
        end
      end
    end

    // R10 bypass, R11 falling-edge retime
    byp = 1;
    set_ctl(1, 0, 0, 1);
    step();
    check(tdo === 1'b0, "R10 bypass captures zero", tdo, 0);
    set_ctl(1, 1, 0, 1);
    step(1);
    check(tdo === 1'b1, "R10 bypass passes tdi", tdo, 1);
    set_ctl(1, 1, 0, 0);
    step(1);
    check(tdo === 1'b0, "R10 bypass one-bit delay", tdo, 0);
    set_ctl(1, 1, 0, 1);
    step(1);
    check(tdo === 1'b1, "R11 tdo after falling edge", tdo, 1);
    byp = 0;

    // R9 reset during an active extest drive
    extest = 1;
    set_ctl(0, 0, 1, 0);
    step();
    set_ctl(0, 0, 0, 0);
    rst_ni = 0;
    #1;
    check(pad_tri === '1, "R9 async reset tristates pads", pad_tri, 5'h1f);
    check(pad_out === '0, "R9 async reset drives outputs low", pad_out, 0);
    check(tdo === 1'b0, "R9 async reset clears tdo", tdo, 0);
    model_reset();
    @(posedge tck);
    @(negedge tck);
    #1;
    rst_ni = 1;
    step();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule